// File: doc/BRIEF.md
# Switch-on-Load Thread Scheduler

This block chooses which hardware thread context a multithreaded core runs. The core owns a fixed set of thread contexts, and each context belongs to that core alone. Exactly one context at a time may hold the core. When the running thread issues any long-latency memory access, whether local or remote, the pipeline raises a one-cycle pulse. The scheduler then parks that thread and hands the core to the oldest waiting thread.

The memory system reports each finished access by giving the ID of the thread that was waiting for it. That thread goes back into the waiting pool behind the threads already there. If the pool is empty at a switch, the core idles until a wake-up arrives.

A completion that does not match a parked thread is dropped. It also sets an error flag, which stays set until reset.

Top module: `tsched_top`

## Requirements
- R1: After reset, thread 0 runs (`cur_tid_o`=0, `run_valid_o`=1, `idle_o`=0, `err_o`=0). The pool then holds threads 1 to NUM_THREADS-1 in ascending order.
- R2: Every thread is always in exactly one of three states: running, waiting or parked. At most one thread is running. While `run_valid_o` is 1, the running thread is `cur_tid_o`.
- R3: If `load_issued_i` is sampled high while a thread runs, the pool's oldest thread is shown on `cur_tid_o` after the next clock edge, with `run_valid_o` still 1.
- R4: The thread that issued the access becomes parked. It is not dispatched again until a completion names it.
- R5: A completion for a parked thread puts it at the tail of the pool. Threads are dispatched in the order their completions arrived.
- R6: If the pool is empty when a switch happens, `run_valid_o` drops to 0 and `idle_o` rises after that edge. They stay that way until the pool holds a thread. A thread woken at edge k is dispatched at edge k+1.
- R7: While the core is idle, `load_issued_i` has no effect.
- R8: A completion naming a waiting thread, the running thread, or an ID of NUM_THREADS or above sets `err_o`. It changes no thread state and no pool entry.
- R9: When a switch and a completion for a parked thread share a cycle, the dispatch uses the pool as it was before that wake. The woken thread joins the tail of the pool.
- R10: Once set, `err_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_issued_i | input | 1 | Running thread issued a long-latency access |
| cpl_valid_i | input | 1 | A memory completion is presented |
| cpl_tid_i | input | TID_W | Thread the completion wakes |
| cur_tid_o | output | TID_W | Thread holding the core |
| run_valid_o | output | 1 | `cur_tid_o` is running |
| idle_o | output | 1 | No thread is running |
| err_o | output | 1 | Sticky: a completion did not match a parked thread |

## Verification
The bench builds the block with five threads. Five is not a power of two, so the pool pointers must wrap at a non-binary limit. It also leaves the 3-bit ID codes 5 to 7 free to drive as out-of-range completions. With only four threads in the pool after reset, a short run of switches drains the pool. That brings the idle stall, loads ignored while idle, and a switch coinciding with a wake-up within a few cycles of directed stimulus, before a long random phase.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  typedef enum logic [1:0] {
    TS_READY = 2'b00,
    TS_EXEC  = 2'b01,
    TS_SUSP  = 2'b10
  } tstate_e;
endpackage

// File: rtl/tsched_pool_fifo.sv
// Ring queue of waiting thread IDs; depth equals the thread count, so it cannot overflow.
module tsched_pool_fifo #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [ID_W-1:0] push_id_i,
  input  logic            pop_i,
  output logic [ID_W-1:0] head_id_o,
  output logic            empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = pop_i  ? ptr_inc(rd_q) : rd_q;
    wr_d  = push_i ? ptr_inc(wr_q) : wr_q;
    cnt_d = cnt_q;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= PTR_LAST;
      cnt_q <= CNT_W'(DEPTH - 1);
    end else begin
      if (pop_i)           rd_q  <= rd_d;
      if (push_i)          wr_q  <= wr_d;
      if (push_i != pop_i) cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_we;
    assign slot_we = push_i && (wr_q == PTR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[e] <= (e < DEPTH - 1) ? ID_W'(e + 1) : '0;
      else if (slot_we) mem_q[e] <= push_id_i;
    end
  end

  assign head_id_o = mem_q[rd_q];
  assign empty_o   = (cnt_q == '0);
endmodule

// File: rtl/tsched_state_table.sv
// Per-thread lifecycle state; thread 0 starts running, the rest waiting.
module tsched_state_table
  import tsched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         park_en_i,
  input  logic [TID_W-1:0]             park_tid_i,
  input  logic                         run_en_i,
  input  logic [TID_W-1:0]             run_tid_i,
  input  logic                         wake_en_i,
  input  logic [TID_W-1:0]             wake_tid_i,
  output tstate_e [NUM_THREADS-1:0]    state_o
);
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    localparam logic [TID_W-1:0] MY_ID = TID_W'(g);
    tstate_e st_q, st_d;
    logic    st_en;

    always_comb begin
      st_d = st_q;
      if (park_en_i && park_tid_i == MY_ID) st_d = TS_SUSP;
      if (run_en_i  && run_tid_i  == MY_ID) st_d = TS_EXEC;
      if (wake_en_i && wake_tid_i == MY_ID) st_d = TS_READY;
    end
    assign st_en = (st_d != st_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= (g == 0) ? TS_EXEC : TS_READY;
      else if (st_en) st_q <= st_d;
    end

    assign state_o[g] = st_q;
  end
endmodule

// File: rtl/tsched_top.sv
module tsched_top
  import tsched_pkg::*;
#(
  parameter  int NUM_THREADS = 8,
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_issued_i,
  input  logic             cpl_valid_i,
  input  logic [TID_W-1:0] cpl_tid_i,
  output logic [TID_W-1:0] cur_tid_o,
  output logic             run_valid_o,
  output logic             idle_o,
  output logic             err_o
);
  tstate_e [NUM_THREADS-1:0] thr_state;
  logic [TID_W-1:0] head_tid;
  logic             pool_empty;

  logic [TID_W-1:0] cur_q, cur_d;
  logic             run_q, run_d, err_q, err_d;
  logic             cur_en, run_en, err_en;
  logic             do_switch, want_thread, do_pop;
  logic             cpl_in_range, wake_ok, cpl_bad;
  tstate_e          cpl_state;

  // State of the thread a completion names (guarded against unused ID codes)
  always_comb begin
    cpl_state = TS_READY;
    for (int i = 0; i < NUM_THREADS; i++)
      if (cpl_tid_i == TID_W'(i)) cpl_state = thr_state[i];
  end

  assign cpl_in_range = (32'(cpl_tid_i) < NUM_THREADS);
  assign wake_ok      = cpl_valid_i && cpl_in_range && (cpl_state == TS_SUSP);
  assign cpl_bad      = cpl_valid_i && !wake_ok;

  assign do_switch    = run_q && load_issued_i;
  assign want_thread  = do_switch || !run_q;
  assign do_pop       = want_thread && !pool_empty;

  always_comb begin
    cur_d  = do_pop ? head_tid : cur_q;
    run_d  = do_pop ? 1'b1 : (do_switch ? 1'b0 : run_q);
    err_d  = err_q | cpl_bad;
    cur_en = do_pop;
    run_en = do_pop || do_switch;
    err_en = cpl_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      run_q <= 1'b1;
      err_q <= 1'b0;
    end else begin
      if (cur_en) cur_q <= cur_d;
      if (run_en) run_q <= run_d;
      if (err_en) err_q <= err_d;
    end
  end

  tsched_pool_fifo #(
    .DEPTH (NUM_THREADS),
    .ID_W  (TID_W)
  ) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (wake_ok),
    .push_id_i (cpl_tid_i),
    .pop_i     (do_pop),
    .head_id_o (head_tid),
    .empty_o   (pool_empty)
  );

  tsched_state_table #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
  ) u_states (
    .clk        (clk),
    .rst_n      (rst_n),
    .park_en_i  (do_switch),
    .park_tid_i (cur_q),
    .run_en_i   (do_pop),
    .run_tid_i  (head_tid),
    .wake_en_i  (wake_ok),
    .wake_tid_i (cpl_tid_i),
    .state_o    (thr_state)
  );

  assign cur_tid_o   = cur_q;
  assign run_valid_o = run_q;
  assign idle_o      = !run_q;
  assign err_o       = err_q;
endmodule

// File: rtl/tsched_checker.sv
module tsched_checker
  import tsched_pkg::*;
#(
  parameter  int NUM_THREADS = 8,
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      load_issued_i,
  input logic [TID_W-1:0]          cur_tid_o,
  input logic                      run_valid_o,
  input logic                      err_o,
  input tstate_e [NUM_THREADS-1:0] thr_state
);
  logic [NUM_THREADS-1:0] exec_mask, susp_mask;
  logic                   cur_is_exec;

  always_comb begin
    cur_is_exec = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      exec_mask[i] = (thr_state[i] == TS_EXEC);
      susp_mask[i] = (thr_state[i] == TS_SUSP);
      if (cur_tid_o == TID_W'(i)) cur_is_exec = exec_mask[i];
    end
  end

  // R2: one running thread exactly when the core is busy
  assert_single_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(exec_mask) == int'(run_valid_o));

  // R2: the shown thread is the running one
  assert_cur_is_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid_o |-> cur_is_exec);

  // R3: a switch changes the thread or idles the core on the next cycle
  assert_switch_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid_o && load_issued_i) |=> (!run_valid_o || cur_tid_o != $past(cur_tid_o)));

  // R4: the issuing thread is parked afterwards
  assert_issuer_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid_o && load_issued_i) |=> susp_mask[$past(cur_tid_o)]);

  // R10: error flag holds
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind tsched_top tsched_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .load_issued_i (load_issued_i),
  .cur_tid_o     (cur_tid_o),
  .run_valid_o   (run_valid_o),
  .err_o         (err_o),
  .thr_state     (thr_state)
);

// File: tb/tb_tsched_top.sv
module tb_tsched_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 5;
  localparam int TW = 3;
  localparam int S_READY = 0, S_EXEC = 1, S_SUSP = 2;

  logic clk = 1'b0;
  logic rst_n, load, cv;
  logic [TW-1:0] ctid;
  logic [TW-1:0] cur_tid;
  logic run_valid, idle, err;

  int m_pool[$];
  int m_st[NT];
  int m_cur;
  bit m_run, m_err;
  string tag;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsched_top #(.NUM_THREADS(NT)) dut (
    .clk(clk), .rst_n(rst_n), .load_issued_i(load), .cpl_valid_i(cv),
    .cpl_tid_i(ctid), .cur_tid_o(cur_tid), .run_valid_o(run_valid),
    .idle_o(idle), .err_o(err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "run_valid", int'(run_valid), int'(m_run));
    chk(tag, "idle", int'(idle), int'(!m_run));
    chk(tag, "err", int'(err), int'(m_err));
    if (m_run) chk(tag, "cur_tid", int'(cur_tid), m_cur);
  endtask

  task automatic model_reset();
    m_pool.delete();
    for (int i = 1; i < NT; i++) m_pool.push_back(i);
    m_st[0] = S_EXEC;
    for (int i = 1; i < NT; i++) m_st[i] = S_READY;
    m_cur = 0; m_run = 1'b1; m_err = 1'b0;
  endtask

  task automatic model_step(bit l, bit c, int t);
    bit wake, had, sw;
    int h;
    wake = c && (t < NT) && (m_st[t % NT] == S_SUSP);
    if (c && !wake) m_err = 1'b1;
    had = (m_pool.size() > 0);
    sw  = m_run && l;
    if (sw) m_st[m_cur] = S_SUSP;
    if ((sw || !m_run) && had) begin
      h = m_pool.pop_front();
      m_st[h] = S_EXEC; m_cur = h; m_run = 1'b1;
    end else if (sw) m_run = 1'b0;
    if (wake) begin
      m_st[t] = S_READY;
      m_pool.push_back(t);
    end
  endtask

  task automatic step(bit l, bit c, int t);
    load = l; cv = c; ctid = TW'(t);
    @(posedge clk);
    model_step(l, c, t);
    @(negedge clk);
    load = 1'b0; cv = 1'b0;
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; load = 1'b0; cv = 1'b0; ctid = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; cv = 1'b0; ctid = '0;
    do_reset();
    tag = "R1"; compare();
    chk("R1", "cur_tid after reset", int'(cur_tid), 0);

    // R3: walk the pool in order 1..4
    tag = "R3";
    for (int i = 1; i < NT; i++) begin
      step(1, 0, 0);
      chk("R3", "dispatched id", int'(cur_tid), i);
    end
    // R6: pool empty -> idle
    tag = "R6"; step(1, 0, 0);
    chk("R6", "idle after drain", int'(idle), 1);
    // R7: loads while idle ignored
    tag = "R7"; step(1, 0, 0); step(1, 0, 0);
    chk("R7", "still idle", int'(run_valid), 0);
    // R5/R6: wake 2 then 0, dispatch in arrival order
    tag = "R5";
    step(0, 1, 2);
    chk("R6", "idle on wake edge", int'(run_valid), 0);
    step(0, 1, 0);
    chk("R5", "first woken runs", int'(cur_tid), 2);
    step(1, 0, 0);
    chk("R5", "second woken runs", int'(cur_tid), 0);
    // R4: parked thread 2 not redispatched without completion
    tag = "R4"; step(1, 0, 0);
    chk("R4", "no redispatch", int'(run_valid), 0);

    // R8: completion to a waiting thread
    do_reset(); tag = "R8";
    step(0, 1, 3);
    chk("R8", "err waiting thread", int'(err), 1);
    for (int i = 1; i < NT; i++) step(1, 0, 0);
    step(1, 0, 0);
    chk("R8", "no duplicate entry", int'(idle), 1);
    // R10: sticky
    tag = "R10"; step(0, 1, 1); step(0, 0, 0); step(1, 0, 0);
    chk("R10", "err held", int'(err), 1);
    // R8: completion to running thread
    do_reset(); tag = "R8";
    step(0, 1, 0);
    chk("R8", "err running thread", int'(err), 1);
    chk("R8", "running thread kept", int'(cur_tid), 0);
    // R8: out-of-range id
    do_reset();
    step(0, 1, 6);
    chk("R8", "err id out of range", int'(err), 1);
    step(0, 1, 5);

    // R9: switch coincides with wake on empty pool
    do_reset(); tag = "R9";
    for (int i = 1; i < NT; i++) step(1, 0, 0);
    step(1, 0, 0);
    step(0, 1, 2);
    step(1, 0, 0);
    step(1, 1, 4);
    chk("R9", "idle when pool was empty", int'(run_valid), 0);
    step(0, 0, 0);
    chk("R9", "woken thread after", int'(cur_tid), 4);

    // R2: random traffic, valid completions only, then any IDs
    do_reset(); tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      int t;
      int cand[$];
      bit l, c;
      l = ($urandom % 100) < 45;
      c = ($urandom % 100) < 40;
      for (int i = 0; i < NT; i++) if (m_st[i] == S_SUSP) cand.push_back(i);
      if (n > 3000 || cand.size() == 0) t = int'($urandom % 8);
      else t = cand[$urandom % cand.size()];
      step(l, c, t);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule